// File: doc/BRIEF.md
# Signed Sixteen-Bit Multi-Operation Agent Datapath

This block is the arithmetic engine of one processing cell. Each accepted request carries two signed 16-bit operands, a 3-bit operation code, a saturation select, the column the work came from and a small item tag. The engine returns one 32-bit answer and a one-cycle completion strobe. Add, subtract, compare and the two shifts finish in a single cycle. Multiplication runs over several cycles on the same shifter and adder. It uses radix-4 Booth digits, skips every zero digit and first swaps the operands so that the operand with fewer non-zero digits acts as multiplier. The cost of a product therefore follows the data, which is what lets a load-balancing layer around it see different amounts of work.

Two operations keep a running sum, one of products and one of operand sums. The sum belongs to one origin column. As soon as a request from any other column completes, the old sum leaves on a separate flush port in the same cycle as that request's completion strobe. Accumulation then restarts from zero. A built-in self-test replays one fixed request per operation code through the datapath and raises a sticky fault flag on any wrong answer. It leaves the running sum alone.

Top module: `agentAlu`

## Requirements
- R1: After reset, `inReady` is 1 and `doneValid`, `flushValid`, `stBusy` and `faultFlag` are 0. A request is taken on a rising edge with `inValid` and `inReady` both high. `inReady` then stays low until the completion strobe.
- R2: Opcode values are ADD=0, SUB=1, MUL=2, CMP=3, SHL=4, SHR=5, MAC=6 and ACC=7. ADD and SUB return the sign-extended 32-bit A+B and A−B.
- R3: MUL returns the exact signed 32-bit product A×B.
- R4: For a 16-bit word m, Booth digit i (i=0..7) is formed from bits 2i+1, 2i and 2i−1, with bit −1 taken as 0. The digit is zero when those three bits are all equal. Let nz(m) count the non-zero digits. Let N be the number of rising edges after the accepting edge up to and including the edge that raises `doneValid`. N is 2+min(nz(A),nz(B)) for MUL and MAC, and 1 for every other code.
- R5: CMP returns bit 0 = (A>B), bit 1 = (A==B) and bit 2 = (A<B), all signed, with `inTag` in bits 20:16 and zeros elsewhere.
- R6: SHL returns the zero-extended A shifted left by B[4:0]. SHR returns the sign-extended A shifted arithmetically right by B[4:0]. B[15:5] has no effect on either shift.
- R7: MAC adds A×B and ACC adds A+B to the running sum. The new sum is the result. With `inSat`=1 an out-of-range sum clamps to 0x7FFFFFFF or 0x80000000. With `inSat`=0 it wraps modulo 2^32.
- R8: A sum is active after any MAC or ACC. Suppose a request completes whose `inCol` differs from the column of the active sum. Then `flushValid` pulses with `flushValue` equal to the old sum, in the same cycle as `doneValid`. A MAC or ACC then starts from zero and takes the new column. Any other code leaves no sum active.
- R9: A pulse on `stStart` while idle runs the self-test. During the test `stBusy` is 1 and `inReady` is 0, no completion or flush strobe appears, and the running sum and its column are kept. On a correct datapath `faultFlag` stays 0. Once set, `faultFlag` is cleared only by reset.
- R10: `doneValid` and `flushValid` are single-cycle pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous reset, active low |
| inValid | input | 1 | Request present |
| inReady | output | 1 | Engine can take a request |
| inOp | input | 3 | Operation code |
| inA | input | 16 | Signed operand A |
| inB | input | 16 | Signed operand B or shift amount |
| inSat | input | 1 | 1 saturates the running sum, 0 wraps it |
| inCol | input | 3 | Origin column of the request |
| inTag | input | 5 | Item tag echoed by CMP |
| stStart | input | 1 | Starts the self-test |
| stBusy | output | 1 | Self-test in progress |
| faultFlag | output | 1 | Sticky self-test mismatch |
| doneValid | output | 1 | Result strobe |
| result | output | 32 | Operation result |
| flushValid | output | 1 | Running sum handed out |
| flushValue | output | 32 | Handed-out running sum |

## Verification
A column-change flush and a completion happen in one clock edge. The bench provokes this by sending MAC and ACC requests with a new `inCol` while a saturated, wrapped or negative sum is active, and also with a plain ADD. It samples both strobes at the negative edge after the completing edge. The bench judges the result against its own model of the fresh sum, and `flushValue` against the previous sum. It also checks that the MAC latency follows the Booth digit count of the cheaper operand, and that a self-test run between two same-column requests leaves the sum as it was.

// File: rtl/agentAluPkg.sv
package agentAluPkg;
  localparam int OPND_W      = 16;
  localparam int RES_W       = 32;
  localparam int COL_W       = 3;
  localparam int TAG_W       = 5;
  localparam int NDIG        = OPND_W / 2;
  localparam int DIG_W       = $clog2(NDIG);
  localparam int SHAMT_W     = $clog2(RES_W);
  localparam int CMP_TAG_LSB = 16;
  localparam int ST_COUNT    = 8;
  localparam int ST_IDX_W    = $clog2(ST_COUNT);

  typedef enum logic [2:0] {
    OP_ADD = 3'd0,
    OP_SUB = 3'd1,
    OP_MUL = 3'd2,
    OP_CMP = 3'd3,
    OP_SHL = 3'd4,
    OP_SHR = 3'd5,
    OP_MAC = 3'd6,
    OP_ACC = 3'd7
  } aluOp_e;

  typedef struct packed {
    logic   load;
    logic   mulInit;
    logic   mulStep;
    logic   finish;
    logic   testMode;
    aluOp_e op;
  } ctlStrobe_t;

  typedef struct packed {
    aluOp_e            op;
    logic [OPND_W-1:0] a;
    logic [OPND_W-1:0] b;
    logic [RES_W-1:0]  golden;
  } stVec_t;

  function automatic stVec_t stVector(input logic [ST_IDX_W-1:0] idx);
    stVec_t v;
    case (idx)
      3'd0:    v = '{OP_ADD, 16'd100,  16'hFFE2, 32'h0000_0046};
      3'd1:    v = '{OP_SUB, 16'd5,    16'd9,    32'hFFFF_FFFC};
      3'd2:    v = '{OP_MUL, 16'hFFFD, 16'd7,    32'hFFFF_FFEB};
      3'd3:    v = '{OP_CMP, 16'd2,    16'd2,    32'h0000_0002};
      3'd4:    v = '{OP_SHL, 16'h8001, 16'd4,    32'h0008_0010};
      3'd5:    v = '{OP_SHR, 16'h8000, 16'd3,    32'hFFFF_F000};
      3'd6:    v = '{OP_MAC, 16'd300,  16'hFFFE, 32'hFFFF_FDA8};
      default: v = '{OP_ACC, 16'd1000, 16'd24,   32'h0000_0400};
    endcase
    return v;
  endfunction

  function automatic logic [NDIG-1:0] boothNonZero(input logic [OPND_W-1:0] m);
    logic [OPND_W:0] ext;
    logic [NDIG-1:0] nz;
    ext = {m, 1'b0};
    for (int i = 0; i < NDIG; i++) begin
      nz[i] = (ext[2*i +: 3] != 3'b000) && (ext[2*i +: 3] != 3'b111);
    end
    return nz;
  endfunction
endpackage

// File: rtl/agentAluShift.sv
module agentAluShift
  import agentAluPkg::*;
(
  input  logic [RES_W-1:0]   shData,
  input  logic [SHAMT_W-1:0] shAmt,
  input  logic               shLeft,
  input  logic               shArith,
  output logic [RES_W-1:0]   shOut
);
  logic [RES_W-1:0] stage [SHAMT_W+1];
  logic             fillBit;

  assign fillBit  = shArith & shData[RES_W-1];
  assign stage[0] = shData;

  for (genvar s = 0; s < SHAMT_W; s++) begin : gStage
    localparam int DIST = 1 << s;
    always_comb begin
      if (!shAmt[s])
        stage[s+1] = stage[s];
      else if (shLeft)
        stage[s+1] = {stage[s][RES_W-1-DIST:0], {DIST{1'b0}}};
      else
        stage[s+1] = {{DIST{fillBit}}, stage[s][RES_W-1:DIST]};
    end
  end

  assign shOut = stage[SHAMT_W];
endmodule

// File: rtl/agentAluCtrl.sv
module agentAluCtrl
  import agentAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [2:0]        inOp,
  input  logic [OPND_W-1:0] inA,
  input  logic [OPND_W-1:0] inB,
  input  logic              stStart,
  input  logic              mulEmpty,
  input  logic [RES_W-1:0]  resNext,
  output logic              inReady,
  output logic              stBusy,
  output logic              faultFlag,
  output logic [OPND_W-1:0] selA,
  output logic [OPND_W-1:0] selB,
  output ctlStrobe_t        strobe
);
  typedef enum logic [1:0] {S_IDLE, S_CALC, S_MUL} ctlState_e;

  ctlState_e             state;
  aluOp_e                opReg;
  aluOp_e                selOp;
  logic                  stActive;
  logic [ST_IDX_W-1:0]   stIdx;
  stVec_t                vec;

  assign vec     = stVector(stIdx);
  assign selA    = stActive ? vec.a  : inA;
  assign selB    = stActive ? vec.b  : inB;
  assign selOp   = stActive ? vec.op : aluOp_e'(inOp);
  assign inReady = (state == S_IDLE) && !stActive && !stStart;
  assign stBusy  = stActive;

  always_comb begin
    strobe          = '0;
    strobe.op       = opReg;
    strobe.testMode = stActive;
    case (state)
      S_IDLE: strobe.load = stActive || (inValid && inReady);
      S_CALC: begin
        if (opReg == OP_MUL || opReg == OP_MAC) strobe.mulInit = 1'b1;
        else                                    strobe.finish  = 1'b1;
      end
      default: begin
        if (mulEmpty) strobe.finish  = 1'b1;
        else          strobe.mulStep = 1'b1;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= S_IDLE;
      opReg     <= OP_ADD;
      stActive  <= 1'b0;
      stIdx     <= '0;
      faultFlag <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (strobe.load) begin
            opReg <= selOp;
            state <= S_CALC;
          end else if (stStart) begin
            stActive <= 1'b1;
            stIdx    <= '0;
          end
        end
        S_CALC:  state <= strobe.mulInit ? S_MUL : S_IDLE;
        default: if (mulEmpty) state <= S_IDLE;
      endcase
      if (strobe.finish && stActive) begin
        if (resNext != vec.golden) faultFlag <= 1'b1;
        if (stIdx == ST_IDX_W'(ST_COUNT - 1)) stActive <= 1'b0;
        else                                  stIdx    <= stIdx + 1'b1;
      end
    end
  end

  AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    faultFlag |=> faultFlag); // R9
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && inReady) |=> !inReady); // R1
  AST_TEST_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rstN)
    stBusy |-> !inReady); // R9
endmodule

// File: rtl/agentAluDp.sv
module agentAluDp
  import agentAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  ctlStrobe_t        strobe,
  input  logic [OPND_W-1:0] selA,
  input  logic [OPND_W-1:0] selB,
  input  logic              inSat,
  input  logic [COL_W-1:0]  inCol,
  input  logic [TAG_W-1:0]  inTag,
  output logic              mulEmpty,
  output logic [RES_W-1:0]  resNext,
  output logic              doneValid,
  output logic [RES_W-1:0]  result,
  output logic              flushValid,
  output logic [RES_W-1:0]  flushValue
);
  localparam logic [RES_W-1:0] SAT_MAX = {1'b0, {(RES_W-1){1'b1}}};
  localparam logic [RES_W-1:0] SAT_MIN = {1'b1, {(RES_W-1){1'b0}}};

  logic [OPND_W-1:0] rA, rB, rMul;
  logic              rSat;
  logic [COL_W-1:0]  rCol, accCol;
  logic [TAG_W-1:0]  rTag;
  logic [RES_W-1:0]  mcand, prod, acc;
  logic [NDIG-1:0]   mask;
  logic              accActive;

  logic [RES_W-1:0]  sextA, sextB, zextA;
  logic [DIG_W-1:0]  stepIdx;
  logic [OPND_W:0]   mulExt;
  logic [2:0]        digit;
  logic              digNeg, digDouble;
  logic [RES_W-1:0]  shData, shOut, term;
  logic [SHAMT_W-1:0] shAmt;
  logic              shLeft, shArith;
  logic [RES_W-1:0]  addX, addY, addOut;
  logic              addSub;
  logic              flushNow, isAccOp;
  logic [RES_W-1:0]  accBase, accIn, accNew;
  logic [RES_W:0]    accSum;
  logic              accOvf;
  logic [NDIG-1:0]   nzA, nzB;
  logic              swapOps;
  logic              cmpGt, cmpEq, cmpLt;

  assign sextA = {{(RES_W-OPND_W){rA[OPND_W-1]}}, rA};
  assign sextB = {{(RES_W-OPND_W){rB[OPND_W-1]}}, rB};
  assign zextA = {{(RES_W-OPND_W){1'b0}}, rA};

  always_comb begin
    stepIdx = '0;
    for (int i = NDIG - 1; i >= 0; i--) begin
      if (mask[i]) stepIdx = DIG_W'(i);
    end
  end

  assign mulExt    = {rMul, 1'b0};
  assign digit     = mulExt[{stepIdx, 1'b0} +: 3];
  assign digNeg    = digit[2];
  assign digDouble = (digit == 3'b011) || (digit == 3'b100);

  always_comb begin
    if (strobe.mulStep) begin
      shData  = mcand;
      shAmt   = SHAMT_W'({stepIdx, 1'b0});
      shLeft  = 1'b1;
      shArith = 1'b0;
    end else if (strobe.op == OP_SHR) begin
      shData  = sextA;
      shAmt   = rB[SHAMT_W-1:0];
      shLeft  = 1'b0;
      shArith = 1'b1;
    end else begin
      shData  = zextA;
      shAmt   = rB[SHAMT_W-1:0];
      shLeft  = 1'b1;
      shArith = 1'b0;
    end
  end

  agentAluShift uShift (
    .shData (shData),
    .shAmt  (shAmt),
    .shLeft (shLeft),
    .shArith(shArith),
    .shOut  (shOut)
  );

  assign term = digDouble ? {shOut[RES_W-2:0], 1'b0} : shOut;

  always_comb begin
    if (strobe.mulStep) begin
      addX   = prod;
      addY   = term;
      addSub = digNeg;
    end else begin
      addX   = sextA;
      addY   = sextB;
      addSub = (strobe.op == OP_SUB);
    end
    addOut = addSub ? (addX - addY) : (addX + addY);
  end

  assign isAccOp  = (strobe.op == OP_MAC) || (strobe.op == OP_ACC);
  assign flushNow = !strobe.testMode && accActive && (rCol != accCol);
  assign accBase  = (strobe.testMode || flushNow) ? '0 : acc;
  assign accIn    = (strobe.op == OP_MAC) ? prod : addOut;
  assign accSum   = {accBase[RES_W-1], accBase} + {accIn[RES_W-1], accIn};
  assign accOvf   = accSum[RES_W] != accSum[RES_W-1];

  always_comb begin
    if (rSat && accOvf) accNew = accSum[RES_W] ? SAT_MIN : SAT_MAX;
    else                accNew = accSum[RES_W-1:0];
  end

  assign cmpGt = $signed(rA) >  $signed(rB);
  assign cmpEq = rA == rB;
  assign cmpLt = $signed(rA) <  $signed(rB);

  always_comb begin
    resNext = '0;
    case (strobe.op)
      OP_ADD, OP_SUB: resNext = addOut;
      OP_MUL:         resNext = prod;
      OP_CMP: begin
        resNext[CMP_TAG_LSB +: TAG_W] = rTag;
        resNext[2:0] = {cmpLt, cmpEq, cmpGt};
      end
      OP_SHL, OP_SHR: resNext = shOut;
      default:        resNext = accNew;
    endcase
  end

  assign nzA      = boothNonZero(rA);
  assign nzB      = boothNonZero(rB);
  assign swapOps  = $countones(nzA) < $countones(nzB);
  assign mulEmpty = (mask == '0);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rA <= '0; rB <= '0; rMul <= '0; rSat <= 1'b0;
      rCol <= '0; rTag <= '0; accCol <= '0;
      mcand <= '0; prod <= '0; acc <= '0; mask <= '0;
      accActive <= 1'b0;
      doneValid <= 1'b0; result <= '0;
      flushValid <= 1'b0; flushValue <= '0;
    end else begin
      doneValid  <= 1'b0;
      flushValid <= 1'b0;
      if (strobe.load) begin
        rA   <= selA;
        rB   <= selB;
        rSat <= strobe.testMode ? 1'b0 : inSat;
        rCol <= inCol;
        rTag <= strobe.testMode ? '0 : inTag;
      end
      if (strobe.mulInit) begin
        prod <= '0;
        if (swapOps) begin
          rMul  <= rA;
          mcand <= sextB;
          mask  <= nzA;
        end else begin
          rMul  <= rB;
          mcand <= sextA;
          mask  <= nzB;
        end
      end
      if (strobe.mulStep) begin
        prod          <= addOut;
        mask[stepIdx] <= 1'b0;
      end
      if (strobe.finish && !strobe.testMode) begin
        doneValid  <= 1'b1;
        result     <= resNext;
        flushValid <= flushNow;
        if (flushNow) flushValue <= acc;
        if (isAccOp) begin
          acc       <= accNew;
          accActive <= 1'b1;
          accCol    <= rCol;
        end else if (flushNow) begin
          acc       <= '0;
          accActive <= 1'b0;
        end
      end
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid); // R10
  AST_FLUSH_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |=> !flushValid); // R10
  AST_FLUSH_WITH_DONE: assert property (@(posedge clk) disable iff (!rstN)
    flushValid |-> doneValid); // R8
  AST_DIGIT_CONSUMED: assert property (@(posedge clk) disable iff (!rstN)
    strobe.mulStep |=> ($countones(mask) == $countones($past(mask)) - 1)); // R4
endmodule

// File: rtl/agentAlu.sv
module agentAlu
  import agentAluPkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  output logic              inReady,
  input  logic [2:0]        inOp,
  input  logic [OPND_W-1:0] inA,
  input  logic [OPND_W-1:0] inB,
  input  logic              inSat,
  input  logic [COL_W-1:0]  inCol,
  input  logic [TAG_W-1:0]  inTag,
  input  logic              stStart,
  output logic              stBusy,
  output logic              faultFlag,
  output logic              doneValid,
  output logic [RES_W-1:0]  result,
  output logic              flushValid,
  output logic [RES_W-1:0]  flushValue
);
  ctlStrobe_t        strobe;
  logic [OPND_W-1:0] selA, selB;
  logic              mulEmpty;
  logic [RES_W-1:0]  resNext;

  agentAluCtrl uCtrl (
    .clk      (clk),
    .rstN     (rstN),
    .inValid  (inValid),
    .inOp     (inOp),
    .inA      (inA),
    .inB      (inB),
    .stStart  (stStart),
    .mulEmpty (mulEmpty),
    .resNext  (resNext),
    .inReady  (inReady),
    .stBusy   (stBusy),
    .faultFlag(faultFlag),
    .selA     (selA),
    .selB     (selB),
    .strobe   (strobe)
  );

  agentAluDp uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .selA      (selA),
    .selB      (selB),
    .inSat     (inSat),
    .inCol     (inCol),
    .inTag     (inTag),
    .mulEmpty  (mulEmpty),
    .resNext   (resNext),
    .doneValid (doneValid),
    .result    (result),
    .flushValid(flushValid),
    .flushValue(flushValue)
  );

  AST_TEST_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    stBusy |-> (!doneValid && !flushValid)); // R9
endmodule

// File: tb/tb_agentAlu.sv
`timescale 1ns/1ps
module tb_agentAlu;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [2:0]  inOp = 3'd0;
  logic [15:0] inA = '0, inB = '0;
  logic        inSat = 1'b0;
  logic [2:0]  inCol = '0;
  logic [4:0]  inTag = '0;
  logic        stStart = 1'b0;
  logic        stBusy, faultFlag, doneValid, flushValid;
  logic [31:0] result, flushValue;

  int checks = 0;
  int bad = 0;

  logic [31:0] mAcc = '0;
  logic [2:0]  mCol = '0;
  logic        mActive = 1'b0;

  always #2.5 clk = ~clk;

  agentAlu dut (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inReady(inReady),
    .inOp(inOp), .inA(inA), .inB(inB), .inSat(inSat), .inCol(inCol),
    .inTag(inTag), .stStart(stStart), .stBusy(stBusy), .faultFlag(faultFlag),
    .doneValid(doneValid), .result(result), .flushValid(flushValid),
    .flushValue(flushValue)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic int nzCount(input logic [15:0] m);
    int n = 0;
    logic [2:0] t;
    for (int i = 0; i < 8; i++) begin
      t = {m[2*i+1], m[2*i], (i == 0) ? 1'b0 : m[2*i-1]};
      if (t != 3'b000 && t != 3'b111) n++;
    end
    return n;
  endfunction

  function automatic logic [31:0] satAdd(input logic [31:0] base, input logic [31:0] x,
                                         input logic sat);
    longint s;
    s = longint'($signed(base)) + longint'($signed(x));
    if (sat && s > 64'sd2147483647)  return 32'h7FFF_FFFF;
    if (sat && s < -64'sd2147483648) return 32'h8000_0000;
    return s[31:0];
  endfunction

  task automatic runOp(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b,
                       input logic sat, input logic [2:0] col, input logic [4:0] tag);
    logic signed [31:0] sa, sb;
    logic [31:0] exp;
    bit expFlush;
    logic [31:0] oldAcc;
    int expLat, lat, na, nb;
    string req;
    sa = {{16{a[15]}}, a};
    sb = {{16{b[15]}}, b};
    expFlush = mActive && (col != mCol);
    oldAcc = mAcc;
    na = nzCount(a);
    nb = nzCount(b);
    expLat = (op == 3'd2 || op == 3'd6) ? 2 + ((na < nb) ? na : nb) : 1;
    case (op)
      3'd0: begin exp = sa + sb; req = "R2 add"; end
      3'd1: begin exp = sa - sb; req = "R2 sub"; end
      3'd2: begin exp = sa * sb; req = "R3 mul"; end
      3'd3: begin
        exp = '0;
        exp[20:16] = tag;
        exp[0] = sa > sb; exp[1] = sa == sb; exp[2] = sa < sb;
        req = "R5 cmp";
      end
      3'd4: begin exp = {16'h0, a} << b[4:0]; req = "R6 shl"; end
      3'd5: begin exp = sa >>> b[4:0]; req = "R6 shr"; end
      3'd6: begin exp = satAdd(expFlush ? 32'h0 : mAcc, sa * sb, sat); req = "R7 mac"; end
      default: begin exp = satAdd(expFlush ? 32'h0 : mAcc, sa + sb, sat); req = "R7 acc"; end
    endcase
    @(negedge clk);
    while (!inReady) @(negedge clk);
    inValid = 1'b1; inOp = op; inA = a; inB = b; inSat = sat; inCol = col; inTag = tag;
    @(posedge clk);
    @(negedge clk);
    inValid = 1'b0;
    chk(inReady == 1'b0, "R1 busy after accept", {31'h0, inReady}, 32'h0);
    lat = 0;
    do begin
      @(posedge clk);
      lat++;
      @(negedge clk);
    end while (!doneValid && lat < 200);
    chk(doneValid == 1'b1 && result == exp, req, result, exp);
    chk(lat == expLat, "R4 latency", lat, expLat);
    chk(flushValid == expFlush, "R8 flush strobe", {31'h0, flushValid}, {31'h0, expFlush});
    if (expFlush) chk(flushValue == oldAcc, "R8 flush value", flushValue, oldAcc);
    @(negedge clk);
    chk(!doneValid && !flushValid, "R10 single pulse", {30'h0, doneValid, flushValid}, 32'h0);
    if (op == 3'd6 || op == 3'd7) begin
      mAcc = exp; mCol = col; mActive = 1'b1;
    end else if (expFlush) begin
      mAcc = '0; mActive = 1'b0;
    end
  endtask

  task automatic testReset();
    chk(inReady == 1'b1, "R1 reset ready", {31'h0, inReady}, 32'h1);
    chk({doneValid, flushValid, stBusy, faultFlag} == 4'b0, "R1 reset strobes",
        {28'h0, doneValid, flushValid, stBusy, faultFlag}, 32'h0);
  endtask

  task automatic testAddSub();
    runOp(3'd0, 16'd100, 16'hFFE2, 1'b0, 3'd0, 5'd0);
    runOp(3'd0, 16'h7FFF, 16'h7FFF, 1'b0, 3'd0, 5'd0);
    runOp(3'd1, 16'd5, 16'd9, 1'b0, 3'd0, 5'd0);
    runOp(3'd1, 16'h8000, 16'd1, 1'b0, 3'd0, 5'd0);
  endtask

  task automatic testMul();
    runOp(3'd2, 16'd0, 16'd1234, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'h5555, 16'd3, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'd3, 16'h5555, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'h8000, 16'h8000, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'hFFFF, 16'hFFFF, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'h1234, 16'hABCD, 1'b0, 3'd0, 5'd0);
    runOp(3'd2, 16'h7FFF, 16'h8000, 1'b0, 3'd0, 5'd0);
  endtask

  task automatic testCmp();
    runOp(3'd3, 16'd5, 16'd3, 1'b0, 3'd0, 5'd7);
    runOp(3'd3, 16'hFFFC, 16'd2, 1'b0, 3'd0, 5'd31);
    runOp(3'd3, 16'd9, 16'd9, 1'b0, 3'd0, 5'd0);
  endtask

  task automatic testShift();
    runOp(3'd4, 16'h8001, 16'd4, 1'b0, 3'd0, 5'd0);
    runOp(3'd4, 16'hFFFF, 16'd16, 1'b0, 3'd0, 5'd0);
    runOp(3'd4, 16'd1, 16'd31, 1'b0, 3'd0, 5'd0);
    runOp(3'd4, 16'd3, 16'hFFE1, 1'b0, 3'd0, 5'd0);
    runOp(3'd5, 16'h8000, 16'd3, 1'b0, 3'd0, 5'd0);
    runOp(3'd5, 16'h8000, 16'd31, 1'b0, 3'd0, 5'd0);
    runOp(3'd5, 16'h7FFF, 16'hFFE0, 1'b0, 3'd0, 5'd0);
  endtask

  task automatic testAccum();
    for (int i = 0; i < 3; i++) runOp(3'd6, 16'h7FFF, 16'h7FFF, 1'b1, 3'd1, 5'd0);
    runOp(3'd6, 16'hFFFF, 16'd1, 1'b1, 3'd1, 5'd0);
    for (int i = 0; i < 3; i++) runOp(3'd6, 16'h7FFF, 16'h7FFF, 1'b0, 3'd2, 5'd0);
    for (int i = 0; i < 3; i++) runOp(3'd6, 16'h8000, 16'h7FFF, 1'b1, 3'd3, 5'd0);
    runOp(3'd7, 16'h8000, 16'h8000, 1'b1, 3'd3, 5'd0);
    runOp(3'd0, 16'd1, 16'd1, 1'b0, 3'd4, 5'd0);
    runOp(3'd7, 16'd1000, 16'd24, 1'b0, 3'd5, 5'd0);
    runOp(3'd7, 16'h7FFF, 16'h7FFF, 1'b0, 3'd5, 5'd0);
  endtask

  task automatic testSelfTest();
    bit sawOut = 1'b0;
    int n = 0;
    @(negedge clk);
    stStart = 1'b1;
    @(posedge clk);
    @(negedge clk);
    stStart = 1'b0;
    chk(stBusy == 1'b1 && inReady == 1'b0, "R9 busy during test",
        {30'h0, stBusy, inReady}, 32'h2);
    while (stBusy && n < 500) begin
      if (doneValid || flushValid || inReady) sawOut = 1'b1;
      @(negedge clk);
      n++;
    end
    chk(!stBusy, "R9 test ends", {31'h0, stBusy}, 32'h0);
    chk(!sawOut, "R9 no strobes during test", {31'h0, sawOut}, 32'h0);
    chk(!faultFlag, "R9 no fault", {31'h0, faultFlag}, 32'h0);
    runOp(3'd7, 16'd0, 16'd0, 1'b0, mCol, 5'd0);
  endtask

  initial begin
    #(5.0 * 150000);
    bad++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testAddSub();
    testMul();
    testCmp();
    testShift();
    testAccum();
    testSelfTest();
    testSelfTest();
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule